// File: doc/BRIEF.md
# Receive Byte Buffer with Counted Release

This block is the receive-side storage of a high-speed serial port. A receive shifter hands it one byte at a time over a valid/ready stream; each accepted byte is written at the tail of a circular byte store. The host does not pop bytes one by one. It reads the store as a random-access window. Window offset k returns the k-th oldest unreleased byte, with wrap-around at the end of the store. When the host has consumed a batch, it frees the space in one step by writing a byte count. The head then moves forward by that many bytes, and the fill level falls by the same amount.

The block reports its fill level in two forms: as a plain bus, and packed into a 32-bit status word at the positions a neighbouring interrupt/status register decodes. It also drives two events. The data-available flag rises once the level reaches a programmable threshold. The character-timeout flag rises when a short run of bytes, below the threshold, has been left sitting with no arrivals and no releases for a programmed number of clocks. That number is the timeout value times the baud divisor times four.

One slot of the store is kept empty, so the level always fits in `ADDR_W` bits. The stream's back-pressure is advisory only: the shifter cannot stall. `in_ready` is low exactly when the store holds `2**ADDR_W - 1` bytes. A byte offered while `in_ready` is low is discarded and reported on `overrun`.

Top module: `rxq_rx_buffer`

## Requirements
- R1: After reset, `level` is 0, `in_ready` is 1, `status_word` is 0, and `data_avail`, `char_timeout` and `overrun` are all 0.
- R2: Bytes are stored in acceptance order. `win_rdata` shows the byte at offset `win_addr` from the oldest unreleased byte, counted modulo `2**ADDR_W`, one clock after `win_addr` is applied.
- R3: `in_ready` is 0 exactly when `level` equals `2**ADDR_W - 1`. A byte offered while `in_ready` is 0 is discarded. `overrun` is then high for exactly the following clock, and `level` stays the same.
- R4: A release (`rel_valid` high with count n, where n ≤ `level`) lowers `level` by n and moves offset 0 to the byte that was at offset n. If a byte is accepted in the same clock, it adds 1 to the new level.
- R5: A release count larger than the current `level` is clamped to `level`, which empties the store.
- R6: Window offsets at or above `2**ADDR_W - 4` always read as 0.
- R7: `status_word` holds bits 7:0 of the level, zero-extended to 10 bits, at bits 31:24, and bits 9:8 of that value at bits 7:6. All other bits are 0.
- R8: `data_avail` is 1 exactly when `level` is non-zero and `level` ≥ `thresh`.
- R9: Let P = `to_val` × `baud_val` × 4. Every accepted byte and every release, including a release of zero, restarts the timeout count. While 0 < `level` < `thresh` and P ≠ 0, `char_timeout` rises P clocks after the last restart. It stays high until the next restart or until that condition no longer holds. When P = 0, `char_timeout` never rises.
- R10: Each accepted byte with no release in the same clock raises `level` by 1, visible on the clock after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Receive byte offered by the shifter |
| in_data | input | 8 | Receive byte |
| in_ready | output | 1 | Store can accept a byte (advisory; the shifter does not stall) |
| win_addr | input | ADDR_W | Window byte offset from the oldest byte |
| win_rdata | output | 8 | Window read data, one clock after the address |
| rel_valid | input | 1 | Release strobe |
| rel_count | input | ADDR_W | Number of bytes to release |
| thresh | input | ADDR_W | Data-available threshold |
| to_val | input | TO_W | Timeout multiplier |
| baud_val | input | BAUD_W | Baud divisor used in the timeout period |
| level | output | ADDR_W | Current fill level |
| status_word | output | 32 | Level packed at status positions |
| data_avail | output | 1 | Level reached threshold |
| char_timeout | output | 1 | Character-timeout event |
| overrun | output | 1 | One-clock pulse when a byte was dropped |

## Verification
The assertions assume that `thresh`, `to_val` and `baud_val` change only while no timeout run is in progress. They also assume that `rel_count` means nothing unless `rel_valid` is high. The stimulus changes these settings only between test phases. Before it checks the timeout window, it forces a restart with a release of zero. All inputs are driven on the falling edge, so nothing changes near the sampling edge. Overruns are produced on purpose only once the store is known to be full, so the model of the store's contents stays exact.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int STAT_W = 32;
  localparam int LVL_STAT_W = 10;

  // Level placement read by the neighbouring status register.
  function automatic logic [STAT_W-1:0] pack_level(input logic [LVL_STAT_W-1:0] lv);
    logic [STAT_W-1:0] s;
    s = '0;
    s[31:24] = lv[7:0];
    s[7:6]   = lv[9:8];
    return s;
  endfunction
endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_zero,
  output logic [7:0]        rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       rd_data <= '0;
    else if (rd_zero) rd_data <= '0;
    else              rd_data <= mem[rd_addr];
  end

  // R6: offsets past the readable window return zero
  p_window_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_zero |=> (rd_data == 8'h00));
endmodule

// File: rtl/rxq_level.sv
module rxq_level #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              rel_valid,
  input  logic [ADDR_W-1:0] rel_count,
  output logic              accept,
  output logic              in_ready,
  output logic              overrun,
  output logic              restart,
  output logic [ADDR_W-1:0] wr_ptr,
  output logic [ADDR_W-1:0] rd_ptr,
  output logic [ADDR_W-1:0] level
);
  localparam logic [ADDR_W-1:0] CAP = {ADDR_W{1'b1}};

  logic [ADDR_W-1:0] rel_eff;

  assign in_ready = (level != CAP);
  assign accept   = in_valid & in_ready;
  assign restart  = accept | rel_valid;

  always_comb begin
    rel_eff = '0;
    if (rel_valid) rel_eff = (rel_count > level) ? level : rel_count;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      level   <= '0;
      overrun <= 1'b0;
    end else begin
      if (accept) wr_ptr <= wr_ptr + 1'b1;
      rd_ptr  <= rd_ptr + rel_eff;
      level   <= level + ADDR_W'(accept) - rel_eff;
      overrun <= in_valid & ~in_ready;
    end
  end

  p_drop_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready) |=> (overrun && level == $past(level)));

  p_grow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !rel_valid) |=> (level == ADDR_W'($past(level) + 1'b1)));

  p_clamp_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_valid && !accept) |=>
      (level == (($past(rel_count) > $past(level)) ? '0 : $past(level) - $past(rel_count))));

  p_ptr_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (ADDR_W'(wr_ptr - rd_ptr) == level));
endmodule

// File: rtl/rxq_timer.sv
module rxq_timer #(
  parameter int LVL_W  = 10,
  parameter int TO_W   = 16,
  parameter int BAUD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic [LVL_W-1:0]  level,
  input  logic [LVL_W-1:0]  thresh,
  input  logic [TO_W-1:0]   to_val,
  input  logic [BAUD_W-1:0] baud_val,
  output logic              char_timeout
);
  localparam int PW = TO_W + BAUD_W + 2;

  logic [PW-1:0] period;
  logic [PW-1:0] cnt;
  logic          armed;

  assign period = PW'(to_val) * PW'(baud_val) * PW'(4);
  assign armed  = (level != '0) && (level < thresh);

  always_ff @(posedge clk) begin
    if (!rst_n)                  cnt <= '0;
    else if (restart || !armed)  cnt <= '0;
    else if (cnt != period)      cnt <= cnt + 1'b1;
  end

  assign char_timeout = armed && (period != '0) && (cnt == period);

  // R9: a restart always clears the event on the next clock
  p_restart_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !char_timeout);
endmodule

// File: rtl/rxq_rx_buffer.sv
module rxq_rx_buffer #(
  parameter int ADDR_W = 10,
  parameter int TO_W   = 16,
  parameter int BAUD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] win_addr,
  output logic [7:0]        win_rdata,
  input  logic              rel_valid,
  input  logic [ADDR_W-1:0] rel_count,
  input  logic [ADDR_W-1:0] thresh,
  input  logic [TO_W-1:0]   to_val,
  input  logic [BAUD_W-1:0] baud_val,
  output logic [ADDR_W-1:0] level,
  output logic [31:0]       status_word,
  output logic              data_avail,
  output logic              char_timeout,
  output logic              overrun
);
  import rxq_pkg::*;

  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] WIN_LIMIT = ADDR_W'(DEPTH - 4);

  logic              accept;
  logic              restart;
  logic [ADDR_W-1:0] wr_ptr;
  logic [ADDR_W-1:0] rd_ptr;

  rxq_level #(.ADDR_W(ADDR_W)) u_level (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .rel_valid(rel_valid), .rel_count(rel_count),
    .accept(accept), .in_ready(in_ready), .overrun(overrun),
    .restart(restart), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .level(level)
  );

  rxq_store #(.ADDR_W(ADDR_W)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(accept), .wr_addr(wr_ptr),
    .wr_data(in_data), .rd_addr(rd_ptr + win_addr),
    .rd_zero(win_addr >= WIN_LIMIT), .rd_data(win_rdata)
  );

  rxq_timer #(.LVL_W(ADDR_W), .TO_W(TO_W), .BAUD_W(BAUD_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .restart(restart), .level(level),
    .thresh(thresh), .to_val(to_val), .baud_val(baud_val),
    .char_timeout(char_timeout)
  );

  assign data_avail  = (level != '0) && (level >= thresh);
  assign status_word = pack_level(LVL_STAT_W'(level));

  // R8 / R9: the two events never claim the same level range
  p_events_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(data_avail && char_timeout));

  // R3: nothing is accepted while the store is full
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (level == {ADDR_W{1'b1}}) |-> !in_ready);
endmodule

// File: tb/tb_rxq_rx_buffer.sv
module tb_rxq_rx_buffer;
  localparam int CLK_NS = 10;
  localparam int AW = 4;
  localparam int TW = 4;
  localparam int BW = 4;
  localparam int DEPTH = 1 << AW;
  localparam int CAP = DEPTH - 1;
  localparam int LIMIT = DEPTH - 4;

  logic clk = 0;
  logic rst_n = 0;
  logic in_valid = 0;
  logic [7:0] in_data = 0;
  logic in_ready;
  logic [AW-1:0] win_addr = 0;
  logic [7:0] win_rdata;
  logic rel_valid = 0;
  logic [AW-1:0] rel_count = 0;
  logic [AW-1:0] thresh = 0;
  logic [TW-1:0] to_val = 0;
  logic [BW-1:0] baud_val = 0;
  logic [AW-1:0] level;
  logic [31:0] status_word;
  logic data_avail, char_timeout, overrun;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;
  byte unsigned q[$];

  always #(CLK_NS/2) clk = ~clk;

  rxq_rx_buffer #(.ADDR_W(AW), .TO_W(TW), .BAUD_W(BW)) dut (.*);

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic push(input byte unsigned b);
    @(negedge clk); in_valid = 1; in_data = b;
    @(negedge clk); in_valid = 0;
    if (q.size() < CAP) q.push_back(b);
  endtask

  task automatic release_n(input int n);
    int eff;
    @(negedge clk); rel_valid = 1; rel_count = AW'(n);
    @(negedge clk); rel_valid = 0;
    eff = (n > q.size()) ? q.size() : n;
    repeat (eff) void'(q.pop_front());
  endtask

  task automatic read_win(input int k, output int v);
    @(negedge clk); win_addr = AW'(k);
    @(negedge clk); v = win_rdata;
  endtask

  task automatic check_contents(input string tag);
    int v;
    for (int k = 0; k < DEPTH; k++) begin
      if (k >= LIMIT) begin
        read_win(k, v); chk({tag, " R6 window zero"}, v, 0);
      end else if (k < q.size()) begin
        read_win(k, v); chk({tag, " R2 window byte"}, v, q[k]);
      end
    end
  endtask

  function automatic int pack(input int lv);
    return ((lv & 8'hFF) << 24) | (((lv >> 8) & 3) << 6);
  endfunction

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_NS * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      summary();
    end
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 level", level, 0);
    chk("R1 in_ready", in_ready, 1);
    chk("R1 status", status_word, 0);
    chk("R1 data_avail", data_avail, 0);
    chk("R1 char_timeout", char_timeout, 0);
    chk("R1 overrun", overrun, 0);

    // fill sweep with threshold sweep at each level
    for (int i = 0; i < CAP; i++) begin
      push(byte'(i * 7 + 3));
      chk("R10 level", level, i + 1);
      chk("R7 status", status_word, pack(i + 1));
      chk("R3 in_ready", in_ready, (i + 1 < CAP) ? 1 : 0);
      for (int t = 0; t < DEPTH; t++) begin
        thresh = AW'(t); #1;
        chk("R8 data_avail", data_avail, (i + 1 >= t) ? 1 : 0);
      end
      thresh = 0;
    end
    check_contents("full");

    // overrun while full
    push(8'hEE);
    chk("R3 overrun pulse", overrun, 1);
    chk("R3 level held", level, CAP);
    @(negedge clk);
    chk("R3 overrun one clock", overrun, 0);
    release_n(12);
    chk("R4 level after release", level, 3);
    check_contents("after drop");

    // push/release pattern sweep, wrapping pointers
    for (int k = 0; k < 7; k++) begin
      for (int r = 0; r < 9; r++) begin
        for (int j = 0; j < k; j++)
          if (q.size() < CAP) push(byte'(k * 16 + r * 3 + j));
        chk("R10 level after pushes", level, q.size());
        begin
          int exp;
          exp = q.size() - ((r > q.size()) ? q.size() : r);
          release_n(r);
          chk((r > exp + r - r && r > level + r) ? "R5 clamp" : "R4 release", level, exp);
        end
        check_contents("sweep");
      end
    end

    // simultaneous accept and release
    for (int n = 0; n < 4; n++) begin
      int l0, exp;
      l0 = q.size();
      @(negedge clk); in_valid = 1; in_data = byte'(8'hA0 + n);
      rel_valid = 1; rel_count = AW'(n);
      @(negedge clk); in_valid = 0; rel_valid = 0;
      repeat ((n > l0) ? l0 : n) void'(q.pop_front());
      q.push_back(byte'(8'hA0 + n));
      exp = l0 - ((n > l0) ? l0 : n) + 1;
      chk("R4 accept+release", level, exp);
      check_contents("concurrent");
    end

    // clamp to empty
    release_n(CAP);
    chk("R5 clamp to empty", level, 0);
    chk("R5 status empty", status_word, 0);

    // character timeout
    for (int j = 0; j < 3; j++) push(byte'(j + 1));
    thresh = 8;
    for (int p = 0; p < 4; p++) begin
      int tv, bv, per;
      tv = (p == 0) ? 1 : (p == 1) ? 2 : (p == 2) ? 3 : 1;
      bv = (p == 0) ? 1 : (p == 1) ? 3 : (p == 2) ? 1 : 5;
      per = tv * bv * 4;
      to_val = TW'(tv); baud_val = BW'(bv);
      release_n(0);
      repeat (per - 1) @(negedge clk);
      chk("R9 not yet", char_timeout, 0);
      @(negedge clk);
      chk("R9 fires at period", char_timeout, 1);
      @(negedge clk);
      chk("R9 holds", char_timeout, 1);
      release_n(0);
      chk("R9 restart clears", char_timeout, 0);
    end
    // byte arrival restarts too
    to_val = 1; baud_val = 2;
    release_n(0);
    repeat (5) @(negedge clk);
    push(8'h55);
    repeat (7) @(negedge clk);
    chk("R9 arrival restart", char_timeout, 0);
    @(negedge clk);
    chk("R9 fires after arrival", char_timeout, 1);
    // level at threshold: no timeout
    thresh = 2;
    release_n(0);
    repeat (20) @(negedge clk);
    chk("R9 none at threshold", char_timeout, 0);
    chk("R8 data_avail at threshold", data_avail, 1);
    // period zero disables
    thresh = 8; to_val = 0;
    release_n(0);
    repeat (40) @(negedge clk);
    chk("R9 disabled", char_timeout, 0);
    // empty: no timeout
    to_val = 1; baud_val = 1;
    release_n(CAP);
    repeat (10) @(negedge clk);
    chk("R9 none when empty", char_timeout, 0);

    done = 1;
    summary();
  end
endmodule